// File: doc/BRIEF.md
# Hall Sector Decoder

This block watches the three Hall sensor lines of a brushless motor, which arrive already synchronised to the clock. It turns them into a 3-bit rotor sector, works out which way the rotor is turning, and raises a one-cycle interrupt pulse on every sector change. Each input passes a per-line persistence filter first, so a short glitch never reaches the sector.

Every accepted edge is stamped with the value of an external free-running timebase. The revolution period is the time between this edge and the previous edge of the same polarity on the same line, which cancels any mismatch between the sensors. A signed revolution counter steps once per electrical revolution and can be overwritten by software.

On request, the block captures the time of the last accepted edge and the current timebase value in the same cycle, as one word that is read in a single access. The response is a one-cycle `ts_valid` pulse and has no back-pressure: `ts_pair` holds its value until the next request replaces it. All other pins are plain level or pulse signals.

Top module: `hall_sector_decoder`

## Requirements
- R1: `sector` equals the filtered levels {A,B,C} as {bit2,bit1,bit0}. The legal codes are 4 (100), 6 (110), 2 (010), 3 (011), 1 (001) and 5 (101).
- R2: `sector_err` is high exactly while the sector is 0 (000) or 7 (111). A move into or out of those codes leaves `direction` unchanged.
- R3: Between two legal sectors, a step along 4,6,2,3,1,5,4 sets `direction` to 0 and a step along 4,5,1,3,2,6,4 sets it to 1. Any other transition keeps the last direction.
- R4: On each accepted edge, the period is the edge time minus the stored time of the previous edge of the same polarity on the same line, modulo 2^16. If several lines switch in one cycle, line A is used before B, and B before C. The period is loaded in the same cycle the sector changes.
- R5: `period_valid` drops, and `period` holds its value, on an edge whose line and polarity have no stored time since reset or since the last direction change, and on any edge that changes the direction. On every other edge it goes high.
- R6: `sector_irq` is high for exactly the one cycle in which `sector` takes a new value.
- R7: One cycle after `ts_req` is sampled high, `ts_valid` pulses and `ts_pair` holds {last edge time, timebase value at the request} in its upper and lower halves. An edge accepted in the same cycle does not enter the pair.
- R8: A line change is accepted only after the new level has been sampled on FILT_CYC+1 consecutive clocks. The edge time is the timebase value at the first of those clocks. A shorter pulse leaves the sector unchanged.
- R9: Each entry into sector 4 from another legal sector adds 1 to `rev_count` when the updated direction is 0, and subtracts 1 when it is 1, wrapping modulo 2^16.
- R10: `rc_wr_en` loads `rc_wr_data` into `rev_count` on the next clock. A write overrides a step in the same cycle.
- R11: After reset, `sector`, `direction`, `period`, `period_valid`, `rev_count`, `sector_irq`, `ts_valid` and `ts_pair` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_a | input | 1 | Hall line A (synchronised) |
| hall_b | input | 1 | Hall line B (synchronised) |
| hall_c | input | 1 | Hall line C (synchronised) |
| tcr | input | TW | Free-running timebase |
| ts_req | input | 1 | Timestamp capture request |
| rc_wr_en | input | 1 | Revolution counter write strobe |
| rc_wr_data | input | RC_W | Revolution counter write value |
| sector | output | 3 | Decoded rotor sector |
| sector_err | output | 1 | Illegal Hall state flag |
| direction | output | 1 | Rotation direction |
| sector_irq | output | 1 | Sector change pulse |
| period | output | TW | Last revolution time |
| period_valid | output | 1 | Period is meaningful |
| rev_count | output | RC_W | Signed revolution count |
| ts_valid | output | 1 | Timestamp pair ready pulse |
| ts_pair | output | 2*TW | {last edge time, current time} |

## Verification
On every cycle, the assertions check the following. The interrupt pulse coincides with sector changes in both directions. A filtered level only rises after the raw line was high. Direction stays put across illegal states. `period_valid` is low after a direction flip. The revolution counter moves by at most one step unless software wrote it. A timestamp response follows each request. The bench scenarios are the only place where the following can be shown: glitches shorter than the filter window being rejected, the exact period value over several revolutions and speeds, the priority when three lines switch together, timebase wrap, and the counter wrapping through 0x8000.

// File: rtl/hall_pkg.sv
package hall_pkg;
  typedef logic [2:0] sector_t;

  function automatic logic is_legal(sector_t s);
    return (s != 3'd0) && (s != 3'd7);
  endfunction

  // successor when direction is 0
  function automatic sector_t step_fwd(sector_t s);
    case (s)
      3'd4: return 3'd6;
      3'd6: return 3'd2;
      3'd2: return 3'd3;
      3'd3: return 3'd1;
      3'd1: return 3'd5;
      3'd5: return 3'd4;
      default: return s;
    endcase
  endfunction

  // successor when direction is 1
  function automatic sector_t step_rev(sector_t s);
    case (s)
      3'd4: return 3'd5;
      3'd5: return 3'd1;
      3'd1: return 3'd3;
      3'd3: return 3'd2;
      3'd2: return 3'd6;
      3'd6: return 3'd4;
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/hall_filter.sv
module hall_filter #(
  parameter int unsigned TW       = 16,
  parameter int unsigned FILT_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic [TW-1:0] tcr,
  output logic          lvl,
  output logic          acc,
  output logic          nxt,
  output logic [TW-1:0] t_edge
);
  localparam int unsigned CW = $clog2(FILT_CYC + 2);
  localparam logic [CW-1:0] CNT_END = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q;
  logic [TW-1:0] stamp_q;
  logic          diff;

  assign diff   = raw ^ lvl;
  assign acc    = diff && (cnt_q == CNT_END);
  assign nxt    = acc ? raw : lvl;
  assign t_edge = (cnt_q == '0) ? tcr : stamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= 1'b0;
      cnt_q   <= '0;
      stamp_q <= '0;
    end else begin
      lvl <= nxt;
      if (!diff || acc) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
      if (diff && (cnt_q == '0)) stamp_q <= tcr;
    end
  end

  // R8
  filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl) |-> $past(raw));
  // R8
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diff && !acc) |=> (lvl == $past(lvl)));
endmodule

// File: rtl/hall_edge_timer.sv
module hall_edge_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          rising,
  input  logic [TW-1:0] t_edge,
  input  logic          clr,
  output logic [TW-1:0] span,
  output logic          span_ok
);
  logic [TW-1:0] rise_q, fall_q;
  logic          rise_ok_q, fall_ok_q;

  assign span    = t_edge - (rising ? rise_q : fall_q);
  assign span_ok = rising ? rise_ok_q : fall_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q    <= '0;
      fall_q    <= '0;
      rise_ok_q <= 1'b0;
      fall_ok_q <= 1'b0;
    end else begin
      if (clr) begin
        rise_ok_q <= 1'b0;
        fall_ok_q <= 1'b0;
      end
      if (acc && rising) begin
        rise_q    <= t_edge;
        rise_ok_q <= 1'b1;
      end
      if (acc && !rising) begin
        fall_q    <= t_edge;
        fall_ok_q <= 1'b1;
      end
    end
  end

  // R5
  stamp_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rising) |=> rise_ok_q);
endmodule

// File: rtl/hall_motion.sv
module hall_motion
  import hall_pkg::*;
#(
  parameter int unsigned TW   = 16,
  parameter int unsigned RC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_acc,
  input  sector_t         old_sec,
  input  sector_t         new_sec,
  input  logic [TW-1:0]   sel_span,
  input  logic            sel_ok,
  input  logic            rc_wr_en,
  input  logic [RC_W-1:0] rc_wr_data,
  output logic            dir_chg,
  output logic            direction,
  output logic            sector_irq,
  output logic [TW-1:0]   period,
  output logic            period_valid,
  output logic [RC_W-1:0] rev_count
);
  logic both_ok, go_fwd, go_rev, dir_nxt, enter4;

  assign both_ok = is_legal(old_sec) && is_legal(new_sec);
  assign go_fwd  = any_acc && both_ok && (new_sec == step_fwd(old_sec));
  assign go_rev  = any_acc && both_ok && (new_sec == step_rev(old_sec));
  assign dir_nxt = go_fwd ? 1'b0 : (go_rev ? 1'b1 : direction);
  assign dir_chg = dir_nxt != direction;
  assign enter4  = any_acc && (new_sec == 3'd4) && (old_sec != 3'd4) && is_legal(old_sec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      direction    <= 1'b0;
      sector_irq   <= 1'b0;
      period       <= '0;
      period_valid <= 1'b0;
      rev_count    <= '0;
    end else begin
      direction  <= dir_nxt;
      sector_irq <= any_acc && (new_sec != old_sec);
      if (any_acc) begin
        if (dir_chg || !sel_ok) begin
          period_valid <= 1'b0;
        end else begin
          period       <= sel_span;
          period_valid <= 1'b1;
        end
      end
      if (rc_wr_en)    rev_count <= rc_wr_data;
      else if (enter4) rev_count <= dir_nxt ? rev_count - 1'b1 : rev_count + 1'b1;
    end
  end

  // R5
  flip_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (direction != $past(direction)) |-> !period_valid);
  // R9
  rc_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rev_count != $past(rev_count)) && !$past(rc_wr_en)) |->
      (((rev_count - $past(rev_count)) == RC_W'(1)) ||
       (($past(rev_count) - rev_count) == RC_W'(1))));
endmodule

// File: rtl/hall_sector_decoder.sv
module hall_sector_decoder
  import hall_pkg::*;
#(
  parameter int unsigned TW       = 16,
  parameter int unsigned RC_W     = 16,
  parameter int unsigned FILT_CYC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hall_a,
  input  logic            hall_b,
  input  logic            hall_c,
  input  logic [TW-1:0]   tcr,
  input  logic            ts_req,
  input  logic            rc_wr_en,
  input  logic [RC_W-1:0] rc_wr_data,
  output logic [2:0]      sector,
  output logic            sector_err,
  output logic            direction,
  output logic            sector_irq,
  output logic [TW-1:0]   period,
  output logic            period_valid,
  output logic [RC_W-1:0] rev_count,
  output logic            ts_valid,
  output logic [2*TW-1:0] ts_pair
);
  localparam int unsigned NCH = 3;

  logic [NCH-1:0] raw, lvl, acc, nxt, span_ok;
  logic [TW-1:0]  t_edge [NCH];
  logic [TW-1:0]  span   [NCH];
  logic           dir_chg, any_acc, sel_ok;
  logic [TW-1:0]  sel_span, sel_t, last_edge_q;

  assign raw     = {hall_a, hall_b, hall_c};
  assign any_acc = |acc;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hall_filter #(.TW(TW), .FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw[g]), .tcr(tcr),
      .lvl(lvl[g]), .acc(acc[g]), .nxt(nxt[g]), .t_edge(t_edge[g])
    );
    hall_edge_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .acc(acc[g]), .rising(nxt[g]),
      .t_edge(t_edge[g]), .clr(dir_chg), .span(span[g]), .span_ok(span_ok[g])
    );
  end

  // line A (bit 2) wins over B, B over C
  always_comb begin
    sel_span = span[0];
    sel_ok   = span_ok[0];
    sel_t    = t_edge[0];
    for (int i = 1; i < NCH; i++) begin
      if (acc[i]) begin
        sel_span = span[i];
        sel_ok   = span_ok[i];
        sel_t    = t_edge[i];
      end
    end
  end

  hall_motion #(.TW(TW), .RC_W(RC_W)) u_motion (
    .clk(clk), .rst_n(rst_n), .any_acc(any_acc),
    .old_sec(lvl), .new_sec(nxt),
    .sel_span(sel_span), .sel_ok(sel_ok),
    .rc_wr_en(rc_wr_en), .rc_wr_data(rc_wr_data),
    .dir_chg(dir_chg), .direction(direction), .sector_irq(sector_irq),
    .period(period), .period_valid(period_valid), .rev_count(rev_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_edge_q <= '0;
      ts_valid    <= 1'b0;
      ts_pair     <= '0;
    end else begin
      if (any_acc) last_edge_q <= sel_t;
      ts_valid <= ts_req;
      if (ts_req) ts_pair <= {last_edge_q, tcr};
    end
  end

  assign sector     = lvl;
  assign sector_err = !is_legal(lvl);

  // R6
  irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sector_irq |-> (sector != $past(sector)));
  // R6
  change_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sector != $past(sector)) |-> sector_irq);
  // R7
  ts_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_req |=> ts_valid);
  // R2
  illegal_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sector_err |-> $stable(direction));
endmodule

// File: tb/hall_sector_decoder_tb.sv
module hall_sector_decoder_tb;
  localparam int CLK_P = 10;
  localparam int FILT  = 3;
  localparam logic [2:0] FWD [6] = '{3'd4, 3'd6, 3'd2, 3'd3, 3'd1, 3'd5};
  localparam logic [2:0] REV [6] = '{3'd4, 3'd5, 3'd1, 3'd3, 3'd2, 3'd6};

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] h;
  logic [15:0] tcr;
  logic ts_req, rc_wr_en;
  logic [15:0] rc_wr_data;
  logic [2:0] sector;
  logic sector_err, direction, sector_irq, period_valid, ts_valid;
  logic [15:0] period, rev_count;
  logic [31:0] ts_pair;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  always #(CLK_P/2) clk = ~clk;

  hall_sector_decoder #(.TW(16), .RC_W(16), .FILT_CYC(FILT)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_a(h[2]), .hall_b(h[1]), .hall_c(h[0]),
    .tcr(tcr), .ts_req(ts_req), .rc_wr_en(rc_wr_en), .rc_wr_data(rc_wr_data),
    .sector(sector), .sector_err(sector_err), .direction(direction),
    .sector_irq(sector_irq), .period(period), .period_valid(period_valid),
    .rev_count(rev_count), .ts_valid(ts_valid), .ts_pair(ts_pair)
  );

  always @(negedge clk) begin
    if (!rst_n) tcr <= 16'hFF00;
    else        tcr <= tcr + 16'd1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit legal(input logic [2:0] s);
    return s != 3'd0 && s != 3'd7;
  endfunction

  function automatic logic [2:0] succ(input logic [2:0] s, input bit rev);
    for (int i = 0; i < 6; i++) begin
      if (!rev && FWD[i] == s) return FWD[(i + 1) % 6];
      if (rev && REV[i] == s) return REV[(i + 1) % 6];
    end
    return s;
  endfunction

  // behavioural reference
  logic [2:0]  m_lvl;
  int          m_cnt [3];
  logic [15:0] m_obs [3], m_rs [3], m_fs [3];
  bit          m_rok [3], m_fok [3];
  bit          m_dir, m_pv, m_irq, m_tsv;
  logic [15:0] m_per, m_rc, m_last;
  logic [31:0] m_ts;

  always @(posedge clk) begin : model
    logic [2:0]  acc, nl;
    logic [15:0] et [3];
    int          c;
    bit          dn, pol, ok;
    if (!rst_n) begin
      m_lvl = '0; m_dir = 0; m_pv = 0; m_irq = 0; m_tsv = 0;
      m_per = '0; m_rc = '0; m_last = '0; m_ts = '0;
      for (int k = 0; k < 3; k++) begin
        m_cnt[k] = 0; m_obs[k] = '0; m_rs[k] = '0; m_fs[k] = '0;
        m_rok[k] = 0; m_fok[k] = 0;
      end
    end else begin
      acc = '0; nl = m_lvl;
      for (int k = 0; k < 3; k++) begin
        et[k] = m_obs[k];
        if (h[k] != m_lvl[k]) begin
          if (m_cnt[k] == 0) m_obs[k] = tcr;
          et[k] = m_obs[k];
          if (m_cnt[k] == FILT) begin
            acc[k] = 1'b1; nl[k] = h[k]; m_cnt[k] = 0;
          end else m_cnt[k]++;
        end else m_cnt[k] = 0;
      end
      m_tsv = ts_req;
      if (ts_req) m_ts = {m_last, tcr};
      dn = m_dir;
      m_irq = (acc != 0) && (nl != m_lvl);
      if (acc != 0) begin
        c = acc[2] ? 2 : (acc[1] ? 1 : 0);
        if (legal(m_lvl) && legal(nl)) begin
          if (nl == succ(m_lvl, 0)) dn = 0;
          else if (nl == succ(m_lvl, 1)) dn = 1;
        end
        pol = nl[c];
        ok  = pol ? m_rok[c] : m_fok[c];
        if (dn != m_dir || !ok) m_pv = 0;
        else begin
          m_per = et[c] - (pol ? m_rs[c] : m_fs[c]);
          m_pv  = 1;
        end
        if (dn != m_dir)
          for (int k = 0; k < 3; k++) begin m_rok[k] = 0; m_fok[k] = 0; end
        for (int k = 0; k < 3; k++)
          if (acc[k]) begin
            if (nl[k]) begin m_rs[k] = et[k]; m_rok[k] = 1; end
            else       begin m_fs[k] = et[k]; m_fok[k] = 1; end
          end
        m_last = et[c];
      end
      if (rc_wr_en) m_rc = rc_wr_data;
      else if (acc != 0 && nl == 3'd4 && m_lvl != 3'd4 && legal(m_lvl))
        m_rc = dn ? m_rc - 16'd1 : m_rc + 16'd1;
      m_dir = dn;
      m_lvl = nl;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      chk("R1 sector", sector, m_lvl);
      chk("R2 sector_err", sector_err, !legal(m_lvl));
      chk("R3 direction", direction, m_dir);
      chk("R4 period", period, m_per);
      chk("R5 period_valid", period_valid, m_pv);
      chk("R6 sector_irq", sector_irq, m_irq);
      chk("R7 ts_valid", ts_valid, m_tsv);
      chk("R7 ts_pair", ts_pair, m_ts);
      chk("R9 rev_count", rev_count, m_rc);
    end
  end

  task automatic dwell(input logic [2:0] s, input int n);
    h = s;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ts();
    ts_req = 1'b1;
    @(negedge clk);
    ts_req = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0; h = 3'd0; ts_req = 1'b0; rc_wr_en = 1'b0; rc_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 sector", sector, 3'd0);
    chk("R11 direction", direction, 1'b0);
    chk("R11 period", period, 16'd0);
    chk("R11 period_valid", period_valid, 1'b0);
    chk("R11 rev_count", rev_count, 16'd0);
    chk("R11 ts_pair", {31'd0, ts_valid} | ts_pair, 32'd0);
    cmp_on = 1'b1;

    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 6; i++) begin
        if (i == 2) begin dwell(FWD[i], 5); pulse_ts(); dwell(FWD[i], 6); end
        else dwell(FWD[i], 12);
      end
    chk("R3 forward direction", direction, 1'b0);
    chk("R4 forward period", period, 16'd72);
    chk("R5 forward valid", period_valid, 1'b1);

    dwell(3'd4, 12);
    dwell(3'd6, 2);
    dwell(3'd4, 10);
    chk("R8 glitch rejected", sector, 3'd4);

    for (int r = 0; r < 3; r++)
      for (int i = 1; i <= 6; i++) dwell(REV[i % 6], 9);
    chk("R3 reverse direction", direction, 1'b1);
    chk("R4 reverse period", period, 16'd54);
    pulse_ts();
    for (int r = 0; r < 2; r++)
      for (int i = 1; i <= 6; i++) dwell(REV[i % 6], 15);
    chk("R4 slower period", period, 16'd90);

    dwell(3'd6, 10);
    dwell(3'd7, 10);
    chk("R2 illegal seven", sector_err, 1'b1);
    dwell(3'd0, 10);
    chk("R2 illegal zero", sector_err, 1'b1);
    pulse_ts();
    dwell(3'd4, 10);
    chk("R2 legal again", sector_err, 1'b0);

    rc_wr_data = 16'h7FFF; rc_wr_en = 1'b1;
    @(negedge clk);
    rc_wr_en = 1'b0;
    chk("R10 counter write", rev_count, 16'h7FFF);
    for (int r = 0; r < 2; r++)
      for (int i = 1; i <= 6; i++) dwell(FWD[i % 6], 10);
    chk("R9 counter wrap", rev_count, 16'h8001);
    dwell(3'd4, 8);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule